// File: doc/BRIEF.md
# Key-Protected System Control Register File

A bank of 106 word-wide chip-control registers reached over a plain register bus with a byte address, a write strobe with data, and a read strobe with registered read data. The first word holds an unlock key. While that word does not contain the unlock value 0x1688A8A8, writes to the guarded window of byte offsets 0x004 through 0x100 are refused. The key word itself, and every word from 0x104 upward, can always be written.

A fixed set of offsets are status words. Their values come from input ports and are not stored. One offset, 0xC0, is meant to be written only. Reading it still returns the stored word but is flagged. Each refused access produces a one-cycle error pulse. Refused accesses are out-of-range, misaligned, locked, a write to a status word, or a read of the write-only word. The reset contents of every word come from one flat parameter, so a single design serves several chip variants.

Top module: `sysctl_regfile`

## Requirements
- R1: On reset, word i (byte offset 4*i) holds bits [32*i+31:32*i] of the reset image parameter. The default image gives word i the value 0x5C000000 | (i << 8) | (i ^ 0x3C), so the key word resets to 0x5C00003C and the bank starts locked. After reset rd_data_o and err_o are 0.
- R2: An aligned in-range read presents the addressed word on rd_data_o in the cycle after rd_en_i. While rd_en_i is low, rd_data_o holds its last value.
- R3: The key word at offset 0x000 accepts every write. Once it holds 0x1688A8A8, offsets 0x004..0x100 accept writes from the next cycle on. Writing any other value to it locks that window again from the next cycle.
- R4: While locked, a write to 0x004..0x100 leaves the word unchanged and pulses err_o.
- R5: Offsets 0x104..0x1A4 accept writes whether the bank is locked or not.
- R6: The status offsets map to fields of ro_words_i. Offset 0x14 maps to slot 0, 0x50..0x6C to slots 1..8, 0x78 to 9, 0x7C to 10, 0xE0 to 11 and 0xE4 to 12, with slot s at bits [32*s+31:32*s]. A read returns that field. A write is dropped and pulses err_o.
- R7: A read of offset 0xC0 returns the stored word and pulses err_o. Writes to 0xC0 are ordinary.
- R8: An access at byte offset 0x1A8 or above reads as 0 with err_o. A write there changes no word and pulses err_o.
- R9: An access with addr_i[1:0] != 0 is refused: a read returns 0, a write changes nothing, and err_o pulses.
- R10: err_o is high for exactly the cycle after a refused access and low after accepted or idle cycles.
- R11: A read and a write in the same cycle see one address. The read returns the value from before the write, and err_o pulses if either half is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (12) | Byte address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| ro_words_i | input | 13*32 | Status word fields, slot s at bits 32*s upward |
| rd_data_o | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle pulse for a refused access |

## Verification
A read and a write can land in the same cycle on the same address. In that case the read must return the old contents and the error output must combine both halves. The bench drives both strobes together on an unlocked ordinary word, on a status word and on the guarded window. It checks the read data against the value the model held before that cycle, and checks err_o against the OR of the two refusal conditions. It also writes a new key and then, in the very next cycle, writes the guarded window. This shows that the lock state seen by a write is the one stored before that cycle.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned NWORDS      = 106;
  localparam logic [WORD_W-1:0] UNLOCK_WORD = 32'h1688_A8A8;
  localparam int unsigned KEY_IDX     = 0;
  localparam int unsigned GUARD_FIRST = 1;
  localparam int unsigned GUARD_LAST  = 64;
  localparam int unsigned WO_IDX      = 48;
  localparam int unsigned NUM_RO      = 13;
  // word indices of status words, listed in slot order
  localparam int unsigned RO_MAP [NUM_RO] =
    '{5, 20, 21, 22, 23, 24, 25, 26, 27, 30, 31, 56, 57};

  function automatic logic is_ro_word(int unsigned idx);
    logic hit = 1'b0;
    for (int k = 0; k < NUM_RO; k++) if (RO_MAP[k] == idx) hit = 1'b1;
    return hit;
  endfunction

  function automatic logic [NWORDS*WORD_W-1:0] reset_image();
    logic [NWORDS*WORD_W-1:0] img = '0;
    for (int i = 0; i < NWORDS; i++)
      img[i*WORD_W +: WORD_W] = 32'h5C00_0000 | (32'(i) << 8) | (32'(i) ^ 32'h3C);
    return img;
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_WORDS = sysctl_pkg::NWORDS,
  parameter int unsigned SLOT_W    = 4,
  localparam int unsigned IDX_W    = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              key_open_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              aligned_o,
  output logic              in_range_o,
  output logic              ro_o,
  output logic              wo_o,
  output logic              locked_o,
  output logic [SLOT_W-1:0] slot_o
);
  import sysctl_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);
  localparam logic [IDX_W-1:0] G_LO     = IDX_W'(GUARD_FIRST);
  localparam logic [IDX_W-1:0] G_HI     = IDX_W'(GUARD_LAST);
  localparam logic [IDX_W-1:0] WO_I     = IDX_W'(WO_IDX);

  assign idx_o      = addr_i[ADDR_W-1:2];
  assign aligned_o  = (addr_i[1:0] == 2'b00);
  assign in_range_o = (idx_o <= LAST_IDX);
  assign wo_o       = (idx_o == WO_I);
  assign locked_o   = (idx_o >= G_LO) && (idx_o <= G_HI) && !key_open_i;

  always_comb begin
    ro_o   = 1'b0;
    slot_o = '0;
    for (int k = 0; k < NUM_RO; k++) begin
      if (idx_o == IDX_W'(RO_MAP[k])) begin
        ro_o   = 1'b1;
        slot_o = SLOT_W'(k);
      end
    end
  end
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store #(
  parameter int unsigned NUM_WORDS = sysctl_pkg::NWORDS,
  parameter int unsigned IDX_W     = 10,
  parameter logic [NUM_WORDS*32-1:0] RST_IMG = sysctl_pkg::reset_image()
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [IDX_W-1:0]          widx_i,
  input  logic [31:0]               wdata_i,
  output logic [NUM_WORDS*32-1:0]   words_o
);
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    if (sysctl_pkg::is_ro_word(g)) begin : g_status
      // status words live outside the bank
      assign words_o[g*32 +: 32] = '0;
    end else begin : g_reg
      logic [31:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                q <= RST_IMG[g*32 +: 32];
        else if (we_i && (widx_i == IDX_W'(g)))     q <= wdata_i;
      end
      assign words_o[g*32 +: 32] = q;
    end
  end
endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux #(
  parameter int unsigned NUM_WORDS = sysctl_pkg::NWORDS,
  parameter int unsigned NUM_RO    = sysctl_pkg::NUM_RO,
  parameter int unsigned IDX_W     = 10,
  parameter int unsigned SLOT_W    = 4
) (
  input  logic [NUM_WORDS*32-1:0] words_i,
  input  logic [NUM_RO*32-1:0]    ro_words_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [SLOT_W-1:0]       slot_i,
  input  logic                    ro_i,
  input  logic                    valid_i,
  output logic [31:0]             data_o
);
  always_comb begin
    data_o = '0;
    if (valid_i) begin
      if (ro_i) data_o = ro_words_i[slot_i*32 +: 32];
      else      data_o = words_i[idx_i*32 +: 32];
    end
  end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_WORDS = sysctl_pkg::NWORDS,
  parameter logic [NUM_WORDS*32-1:0] RST_IMG = sysctl_pkg::reset_image(),
  localparam int unsigned NUM_RO   = sysctl_pkg::NUM_RO,
  localparam int unsigned IDX_W    = ADDR_W - 2,
  localparam int unsigned SLOT_W   = $clog2(NUM_RO)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_en_i,
  input  logic [31:0]          wr_data_i,
  input  logic                 rd_en_i,
  input  logic [NUM_RO*32-1:0] ro_words_i,
  output logic [31:0]          rd_data_o,
  output logic                 err_o
);
  logic [IDX_W-1:0]        idx;
  logic                    aligned, in_range, is_ro, is_wo, locked;
  logic [SLOT_W-1:0]       slot;
  logic [NUM_WORDS*32-1:0] words;
  logic                    key_open;
  logic                    valid, wr_ok, rd_bad, wr_bad;
  logic [31:0]             rd_next;
  logic [31:0]             rd_q;
  logic                    err_q;

  assign key_open = (words[sysctl_pkg::KEY_IDX*32 +: 32] == sysctl_pkg::UNLOCK_WORD);

  sysctl_decode #(
    .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .SLOT_W(SLOT_W)
  ) u_decode (
    .addr_i(addr_i), .key_open_i(key_open), .idx_o(idx), .aligned_o(aligned),
    .in_range_o(in_range), .ro_o(is_ro), .wo_o(is_wo), .locked_o(locked),
    .slot_o(slot)
  );

  assign valid  = aligned && in_range;
  assign wr_ok  = wr_en_i && valid && !is_ro && !locked;
  assign wr_bad = wr_en_i && !wr_ok;
  assign rd_bad = rd_en_i && (!valid || is_wo);

  sysctl_store #(
    .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .RST_IMG(RST_IMG)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_ok), .widx_i(idx),
    .wdata_i(wr_data_i), .words_o(words)
  );

  sysctl_rdmux #(
    .NUM_WORDS(NUM_WORDS), .NUM_RO(NUM_RO), .IDX_W(IDX_W), .SLOT_W(SLOT_W)
  ) u_rdmux (
    .words_i(words), .ro_words_i(ro_words_i), .idx_i(idx), .slot_i(slot),
    .ro_i(is_ro), .valid_i(valid), .data_o(rd_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      err_q <= 1'b0;
    end else begin
      if (rd_en_i) rd_q <= rd_next;
      err_q <= rd_bad || wr_bad;
    end
  end

  assign rd_data_o = rd_q;
  assign err_o     = err_q;
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [31:0]       wr_data_i,
  input logic              rd_en_i,
  input logic [31:0]       rd_data_o,
  input logic              err_o,
  input logic              key_open_i
);
  localparam logic [ADDR_W-1:0] END_ADDR = ADDR_W'(sysctl_pkg::NWORDS * 4);

  // R8
  oor_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && (addr_i >= END_ADDR) |=> (rd_data_o == 32'h0) && err_o);
  // R6
  ro_write_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (addr_i == ADDR_W'(12'h014)) |=> err_o);
  // R7
  wo_read_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && (addr_i == ADDR_W'(12'h0C0)) |=> err_o);
  // R10
  idle_no_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i && !wr_en_i |=> !err_o);
  // R2
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
  // R3
  relock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (addr_i == '0) && (wr_data_i != sysctl_pkg::UNLOCK_WORD) |=> !key_open_i);
  // R3
  unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (addr_i == '0) && (wr_data_i == sysctl_pkg::UNLOCK_WORD) |=> key_open_i);
  // R4
  locked_write_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (addr_i == ADDR_W'(12'h004)) && !key_open_i |=> err_o);
  // R9
  misalign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i || wr_en_i) && (addr_i[1:0] != 2'b00) |=> err_o);
endmodule

bind sysctl_regfile sysctl_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
  .err_o(err_o), .key_open_i(key_open)
);

// File: tb/sim_sysctl_regfile.sv
`timescale 1ns/1ps
module sim_sysctl_regfile;
  localparam int NW  = 106;
  localparam int NRO = 13;
  localparam logic [31:0] KEY = 32'h1688_A8A8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [NRO*32-1:0] ro_bus;
  logic [31:0] rd_data;
  logic err;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_w [NW];

  always #10 clk = ~clk;

  sysctl_regfile u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .ro_words_i(ro_bus),
    .rd_data_o(rd_data), .err_o(err)
  );

  function automatic int slot_of(int i);
    case (i * 4)
      'h14: return 0;
      'h50, 'h54, 'h58, 'h5C, 'h60, 'h64, 'h68, 'h6C: return (i * 4 - 'h50) / 4 + 1;
      'h78: return 9;
      'h7C: return 10;
      'hE0: return 11;
      'hE4: return 12;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] ro_val(int s);
    return 32'hD00D_0000 | 32'(s * 'h111);
  endfunction

  function automatic logic [31:0] read_exp(int i);
    int s = slot_of(i);
    return (s >= 0) ? ro_val(s) : exp_w[i];
  endfunction

  function automatic bit wr_refused(int i);
    if (slot_of(i) >= 0) return 1;
    if (i >= 1 && i <= 64 && exp_w[0] != KEY) return 1;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  // starts and ends at a negedge; results sampled one cycle after the strobe
  task automatic op(input bit rd, input bit wr, input logic [11:0] a, input logic [31:0] d,
                    output logic [31:0] q, output logic e);
    rd_en = rd; wr_en = wr; addr = a; wr_data = d;
    @(negedge clk);
    q = rd_data; e = err;
    rd_en = 0; wr_en = 0;
  endtask

  task automatic read_sweep(input string tag);
    logic [31:0] q; logic e;
    for (int i = 0; i < NW; i++) begin
      op(1, 0, 12'(i * 4), '0, q, e);
      chk(q == read_exp(i), {tag, " data"}, q, read_exp(i));
      chk(e == (i == 48), {tag, " err (R7 at 0xC0)"}, 32'(e), 32'(i == 48));
    end
  endtask

  task automatic write_sweep(input string tag, input logic [31:0] base);
    logic [31:0] q; logic e; bit bad;
    for (int i = 1; i < NW; i++) begin
      bad = wr_refused(i);
      op(0, 1, 12'(i * 4), base ^ 32'(i * 'h10001), q, e);
      chk(e == bad, {tag, " write err"}, 32'(e), 32'(bad));
      if (!bad) exp_w[i] = base ^ 32'(i * 'h10001);
    end
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] q; logic e;
    for (int s = 0; s < NRO; s++) ro_bus[s*32 +: 32] = ro_val(s);
    for (int i = 0; i < NW; i++)
      exp_w[i] = 32'h5C00_0000 | (32'(i) << 8) | (32'(i) ^ 32'h3C);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset outputs
    chk(rd_data == 0, "R1 reset rd_data", rd_data, 0);
    chk(err == 0, "R1 reset err", 32'(err), 0);
    // R1 R2 R6 reset contents
    read_sweep("R1 R6 reset sweep");
    // R4 R5 R6 locked writes
    write_sweep("R4 R5 R6 locked", 32'hA000_0000);
    read_sweep("R4 R5 after locked writes");
    // R3 unlock
    op(0, 1, 12'h000, KEY, q, e);
    chk(e == 0, "R3 key write err", 32'(e), 0);
    exp_w[0] = KEY;
    write_sweep("R3 R6 unlocked", 32'hB000_0000);
    read_sweep("R3 R7 after unlocked writes");
    // R8 out of range
    op(1, 0, 12'h1A8, '0, q, e);
    chk(q == 0 && e, "R8 read 0x1A8", q, 0);
    op(1, 0, 12'hFFC, '0, q, e);
    chk(q == 0 && e, "R8 read 0xFFC", q, 0);
    op(0, 1, 12'h1A8, 32'hDEAD_BEEF, q, e);
    chk(e == 1, "R8 write 0x1A8 err", 32'(e), 1);
    // R9 misaligned
    op(1, 0, 12'h006, '0, q, e);
    chk(q == 0 && e, "R9 misaligned read", q, 0);
    op(0, 1, 12'h105, 32'h1234_5678, q, e);
    chk(e == 1, "R9 misaligned write err", 32'(e), 1);
    // R10 idle cycle after a refused access
    op(0, 0, 12'h000, '0, q, e);
    chk(e == 0, "R10 err drops after pulse", 32'(e), 0);
    op(1, 0, 12'h104, '0, q, e);
    chk(q == exp_w[65], "R9 word 0x104 untouched", q, exp_w[65]);
    // R11 read and write together
    op(1, 1, 12'h108, 32'hCAFE_0108, q, e);
    chk(q == exp_w[66] && !e, "R11 rd+wr returns old", q, exp_w[66]);
    exp_w[66] = 32'hCAFE_0108;
    op(1, 0, 12'h108, '0, q, e);
    chk(q == exp_w[66], "R11 new value after rd+wr", q, exp_w[66]);
    op(1, 1, 12'h014, 32'h0, q, e);
    chk(q == ro_val(0) && e, "R11 R6 rd+wr status word", q, ro_val(0));
    op(1, 1, 12'h0C0, 32'h0000_C0C0, q, e);
    chk(q == exp_w[48] && e, "R11 R7 rd+wr write-only word", q, exp_w[48]);
    exp_w[48] = 32'h0000_C0C0;
    // R3 relock, then guarded write in the very next cycle
    op(0, 1, 12'h000, 32'h0000_0001, q, e);
    chk(e == 0, "R3 relock write err", 32'(e), 0);
    exp_w[0] = 32'h0000_0001;
    op(1, 1, 12'h004, 32'h5555_5555, q, e);
    chk(q == exp_w[1] && e, "R3 R4 R11 locked rd+wr", q, exp_w[1]);
    op(1, 0, 12'h004, '0, q, e);
    chk(q == exp_w[1] && !e, "R4 guarded word unchanged", q, exp_w[1]);
    // R3 unlock followed at once by a guarded write
    op(0, 1, 12'h000, KEY, q, e);
    exp_w[0] = KEY;
    op(0, 1, 12'h100, 32'h7777_0100, q, e);
    chk(e == 0, "R3 write right after unlock", 32'(e), 0);
    exp_w[64] = 32'h7777_0100;
    // R2 hold while idle
    op(1, 0, 12'h100, '0, q, e);
    op(0, 0, 12'h000, '0, q, e);
    chk(q == exp_w[64], "R2 rd_data holds", q, exp_w[64]);
    read_sweep("R2 final sweep");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule